// File: doc/BRIEF.md
# Instruction prefix extension unit

This unit is the one-cycle prefix holding stage of a small 16-bit processor in which every instruction completes in one clock. A prefix-load instruction presents a write strobe, an 8-bit high byte and a 3-bit index extension. The unit stores these and merges them into the operands of the instruction in the next active cycle. That instruction's result is a full 16-bit immediate, a 5-bit destination index, a 5-bit source index and a branch classification of absolute or relative. After that cycle the held prefix returns to zero on its own.

A separate valid flag records that a prefix write took place. The flag, not the byte value, makes a branch absolute, so a prefix of 00h still produces an absolute branch. A stall input freezes the held prefix and the flag until the pipeline moves again. The operand merge is combinational: outputs follow the current instruction inputs in the same cycle.

Top module: `pfx_ext_unit`

## Requirements
- R1: The low immediate byte, the low 3 destination index bits and the low 4 source index bits pass combinationally from the current instruction to the outputs in the same cycle.
- R2: After a prefix write in an unstalled cycle, the next cycle's immediate output carries the written byte in bits 15:8.
- R3: When the previous active cycle had no prefix write, immediate bits 15:8, destination bits 4:3 and source bit 4 are all zero.
- R4: In the 3-bit prefix index, bit 0 becomes source index bit 4, and bits 2:1 become destination index bits 4:3 in the following cycle.
- R5: A branch in the cycle after a prefix write is flagged absolute, including when the written byte is 00h. Without such a write the branch is flagged relative. With no branch, both flags are low, and the two flags are never high together.
- R6: Two prefix writes in consecutive cycles leave only the second one in effect for the next instruction.
- R7: While stall is high, the held byte, the index bits and the valid flag keep their values, and prefix writes are ignored. They clear after the first unstalled cycle.
- R8: Asynchronous active-low reset clears the held byte, the index bits and the valid flag at once.
- R9: A single prefix write supplies both the immediate high byte and the index high bits to the same following instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Pipeline stall; holds the prefix state |
| pfx_wr_i | input | 1 | Prefix-load strobe |
| pfx_data_i | input | 8 | Immediate high byte to hold |
| pfx_idx_i | input | 3 | Index extension bits to hold |
| imm_lo_i | input | 8 | Low immediate byte of the current instruction |
| dst_idx_i | input | 3 | Low destination index bits |
| src_idx_i | input | 4 | Low source index bits |
| branch_i | input | 1 | Current instruction is a branch |
| imm_o | output | 16 | Merged immediate |
| dst_idx_o | output | 5 | Widened destination index |
| src_idx_o | output | 5 | Widened source index |
| br_abs_o | output | 1 | Branch is absolute |
| br_rel_o | output | 1 | Branch is relative |

## Verification
Two functions can meet in one cycle: a stall and a new prefix write. The test first loads a prefix, then raises stall together with a second write that carries different data and index bits. It checks that the outputs still show the first prefix through the stall and during the unstalled cycle after it, with the branch still absolute. The outputs must clear only after that cycle. A prefix that switches to the second data, or that is lost during the stall, is reported as a failure.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned BYTE_W_D   = 8;
  localparam int unsigned DST_LO_W_D = 3;
  localparam int unsigned DST_HI_W_D = 2;
  localparam int unsigned SRC_LO_W_D = 4;
  localparam int unsigned SRC_HI_W_D = 1;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_REL  = 2'b01,
    BR_ABS  = 2'b10
  } br_kind_e;
endpackage

// File: rtl/pfx_hold_reg.sv
module pfx_hold_reg #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [PIDX_W-1:0] idx_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [PIDX_W-1:0] idx_o,
  output logic              vld_o
);
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [PIDX_W-1:0] idx_q, idx_d;
  logic              vld_q, vld_d;
  logic              adv;

  // State moves only in unstalled cycles
  assign adv = ~stall_i;

  always_comb begin
    vld_d = wr_i;
    hi_d  = wr_i ? data_i : '0;
    idx_d = wr_i ? idx_i  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else if (adv) begin
      hi_q  <= hi_d;
      idx_q <= idx_d;
      vld_q <= vld_d;
    end
  end

  assign hi_o  = hi_q;
  assign idx_o = idx_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/pfx_operand_merge.sv
module pfx_operand_merge #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned DST_LO_W = 3,
  parameter int unsigned DST_HI_W = 2,
  parameter int unsigned SRC_LO_W = 4,
  parameter int unsigned SRC_HI_W = 1,
  localparam int unsigned PIDX_W  = DST_HI_W + SRC_HI_W,
  localparam int unsigned DST_W   = DST_LO_W + DST_HI_W,
  localparam int unsigned SRC_W   = SRC_LO_W + SRC_HI_W
) (
  input  logic [BYTE_W-1:0]   hi_i,
  input  logic [PIDX_W-1:0]   pidx_i,
  input  logic [BYTE_W-1:0]   lo_i,
  input  logic [DST_LO_W-1:0] dst_lo_i,
  input  logic [SRC_LO_W-1:0] src_lo_i,
  output logic [2*BYTE_W-1:0] imm_o,
  output logic [DST_W-1:0]    dst_o,
  output logic [SRC_W-1:0]    src_o
);
  logic [SRC_HI_W-1:0] src_hi;
  logic [DST_HI_W-1:0] dst_hi;

  // Low part of the extension feeds the source index, the rest the destination
  genvar g;
  generate
    for (g = 0; g < SRC_HI_W; g++) begin : g_src_hi
      assign src_hi[g] = pidx_i[g];
    end
    for (g = 0; g < DST_HI_W; g++) begin : g_dst_hi
      assign dst_hi[g] = pidx_i[SRC_HI_W + g];
    end
  endgenerate

  always_comb begin
    imm_o = {hi_i, lo_i};
    dst_o = {dst_hi, dst_lo_i};
    src_o = {src_hi, src_lo_i};
  end
endmodule

// File: rtl/pfx_branch_kind.sv
module pfx_branch_kind
  import pfx_pkg::*;
(
  input  logic     branch_i,
  input  logic     vld_i,
  output br_kind_e kind_o
);
  always_comb begin
    if (!branch_i)  kind_o = BR_NONE;
    else if (vld_i) kind_o = BR_ABS;
    else            kind_o = BR_REL;
  end
endmodule

// File: rtl/pfx_ext_unit.sv
module pfx_ext_unit
  import pfx_pkg::*;
#(
  parameter int unsigned BYTE_W   = BYTE_W_D,
  parameter int unsigned DST_LO_W = DST_LO_W_D,
  parameter int unsigned DST_HI_W = DST_HI_W_D,
  parameter int unsigned SRC_LO_W = SRC_LO_W_D,
  parameter int unsigned SRC_HI_W = SRC_HI_W_D,
  localparam int unsigned PIDX_W  = DST_HI_W + SRC_HI_W,
  localparam int unsigned DST_W   = DST_LO_W + DST_HI_W,
  localparam int unsigned SRC_W   = SRC_LO_W + SRC_HI_W,
  localparam int unsigned IMM_W   = 2 * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall_i,
  input  logic                pfx_wr_i,
  input  logic [BYTE_W-1:0]   pfx_data_i,
  input  logic [PIDX_W-1:0]   pfx_idx_i,
  input  logic [BYTE_W-1:0]   imm_lo_i,
  input  logic [DST_LO_W-1:0] dst_idx_i,
  input  logic [SRC_LO_W-1:0] src_idx_i,
  input  logic                branch_i,
  output logic [IMM_W-1:0]    imm_o,
  output logic [DST_W-1:0]    dst_idx_o,
  output logic [SRC_W-1:0]    src_idx_o,
  output logic                br_abs_o,
  output logic                br_rel_o
);
  logic [BYTE_W-1:0] held_hi;
  logic [PIDX_W-1:0] held_idx;
  logic              held_vld;
  br_kind_e          br_kind;

  pfx_hold_reg #(
    .BYTE_W (BYTE_W),
    .PIDX_W (PIDX_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .wr_i    (pfx_wr_i),
    .data_i  (pfx_data_i),
    .idx_i   (pfx_idx_i),
    .hi_o    (held_hi),
    .idx_o   (held_idx),
    .vld_o   (held_vld)
  );

  pfx_operand_merge #(
    .BYTE_W   (BYTE_W),
    .DST_LO_W (DST_LO_W),
    .DST_HI_W (DST_HI_W),
    .SRC_LO_W (SRC_LO_W),
    .SRC_HI_W (SRC_HI_W)
  ) u_merge (
    .hi_i     (held_hi),
    .pidx_i   (held_idx),
    .lo_i     (imm_lo_i),
    .dst_lo_i (dst_idx_i),
    .src_lo_i (src_idx_i),
    .imm_o    (imm_o),
    .dst_o    (dst_idx_o),
    .src_o    (src_idx_o)
  );

  pfx_branch_kind u_br (
    .branch_i (branch_i),
    .vld_i    (held_vld),
    .kind_o   (br_kind)
  );

  assign br_abs_o = (br_kind == BR_ABS);
  assign br_rel_o = (br_kind == BR_REL);
endmodule

// File: rtl/pfx_ext_unit_chk.sv
module pfx_ext_unit_chk #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned DST_LO_W = 3,
  parameter int unsigned DST_HI_W = 2,
  parameter int unsigned SRC_LO_W = 4,
  parameter int unsigned SRC_HI_W = 1,
  localparam int unsigned PIDX_W  = DST_HI_W + SRC_HI_W,
  localparam int unsigned DST_W   = DST_LO_W + DST_HI_W,
  localparam int unsigned SRC_W   = SRC_LO_W + SRC_HI_W,
  localparam int unsigned IMM_W   = 2 * BYTE_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stall_i,
  input logic                pfx_wr_i,
  input logic [BYTE_W-1:0]   pfx_data_i,
  input logic [PIDX_W-1:0]   pfx_idx_i,
  input logic [BYTE_W-1:0]   imm_lo_i,
  input logic [DST_LO_W-1:0] dst_idx_i,
  input logic [SRC_LO_W-1:0] src_idx_i,
  input logic                branch_i,
  input logic [IMM_W-1:0]    imm_o,
  input logic [DST_W-1:0]    dst_idx_o,
  input logic [SRC_W-1:0]    src_idx_o,
  input logic                br_abs_o,
  input logic                br_rel_o
);
  // R1
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_o[BYTE_W-1:0] == imm_lo_i) && (dst_idx_o[DST_LO_W-1:0] == dst_idx_i)
    && (src_idx_o[SRC_LO_W-1:0] == src_idx_i));

  // R2
  hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && pfx_wr_i) |=> (imm_o[IMM_W-1:BYTE_W] == $past(pfx_data_i)));

  // R3
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !pfx_wr_i) |=> ((imm_o[IMM_W-1:BYTE_W] == '0)
    && (dst_idx_o[DST_W-1:DST_LO_W] == '0) && (src_idx_o[SRC_W-1:SRC_LO_W] == '0)));

  // R4
  idx_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && pfx_wr_i) |=> ((src_idx_o[SRC_W-1:SRC_LO_W] == $past(pfx_idx_i[SRC_HI_W-1:0]))
    && (dst_idx_o[DST_W-1:DST_LO_W] == $past(pfx_idx_i[PIDX_W-1:SRC_HI_W]))));

  // R5
  abs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && pfx_wr_i) |=> (br_abs_o == branch_i));

  // R5
  br_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({br_abs_o, br_rel_o}) && (branch_i == (br_abs_o | br_rel_o)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(imm_o[IMM_W-1:BYTE_W]) && $stable(dst_idx_o[DST_W-1:DST_LO_W])
    && $stable(src_idx_o[SRC_W-1:SRC_LO_W])));
endmodule

bind pfx_ext_unit pfx_ext_unit_chk #(
  .BYTE_W   (BYTE_W),
  .DST_LO_W (DST_LO_W),
  .DST_HI_W (DST_HI_W),
  .SRC_LO_W (SRC_LO_W),
  .SRC_HI_W (SRC_HI_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall_i    (stall_i),
  .pfx_wr_i   (pfx_wr_i),
  .pfx_data_i (pfx_data_i),
  .pfx_idx_i  (pfx_idx_i),
  .imm_lo_i   (imm_lo_i),
  .dst_idx_i  (dst_idx_i),
  .src_idx_i  (src_idx_i),
  .branch_i   (branch_i),
  .imm_o      (imm_o),
  .dst_idx_o  (dst_idx_o),
  .src_idx_o  (src_idx_o),
  .br_abs_o   (br_abs_o),
  .br_rel_o   (br_rel_o)
);

// File: tb/tb_pfx_ext_unit.sv
module tb_pfx_ext_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        stall_i;
  logic        pfx_wr_i;
  logic [7:0]  pfx_data_i;
  logic [2:0]  pfx_idx_i;
  logic [7:0]  imm_lo_i;
  logic [2:0]  dst_idx_i;
  logic [3:0]  src_idx_i;
  logic        branch_i;
  logic [15:0] imm_o;
  logic [4:0]  dst_idx_o;
  logic [4:0]  src_idx_o;
  logic        br_abs_o;
  logic        br_rel_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pfx_ext_unit dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .pfx_wr_i(pfx_wr_i),
    .pfx_data_i(pfx_data_i), .pfx_idx_i(pfx_idx_i), .imm_lo_i(imm_lo_i),
    .dst_idx_i(dst_idx_i), .src_idx_i(src_idx_i), .branch_i(branch_i),
    .imm_o(imm_o), .dst_idx_o(dst_idx_o), .src_idx_o(src_idx_o),
    .br_abs_o(br_abs_o), .br_rel_o(br_rel_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Check every output against expected values
  task automatic chk_all(input string req, input logic [15:0] imm, input logic [4:0] dst,
                         input logic [4:0] src, input logic abs, input logic rel);
    chk({req, " imm"}, 32'(imm_o), 32'(imm));
    chk({req, " dst"}, 32'(dst_idx_o), 32'(dst));
    chk({req, " src"}, 32'(src_idx_o), 32'(src));
    chk({req, " abs"}, 32'(br_abs_o), 32'(abs));
    chk({req, " rel"}, 32'(br_rel_o), 32'(rel));
  endtask

  // Drive one cycle's inputs at the falling edge, then settle
  task automatic drive(input logic st, input logic wr, input logic [7:0] d, input logic [2:0] px,
                       input logic [7:0] lo, input logic [2:0] ds, input logic [3:0] sr,
                       input logic br);
    @(negedge clk);
    stall_i = st; pfx_wr_i = wr; pfx_data_i = d; pfx_idx_i = px;
    imm_lo_i = lo; dst_idx_i = ds; src_idx_i = sr; branch_i = br;
    #1;
  endtask

  task automatic t_reset;
    drive(0, 0, 8'h00, 3'b000, 8'h5A, 3'd3, 4'd9, 1'b1);
    chk_all("R8 reset state", 16'h005A, 5'd3, 5'd9, 1'b0, 1'b1);
  endtask

  task automatic t_plain;
    drive(0, 0, 8'hFF, 3'b111, 8'hA5, 3'd5, 4'hC, 1'b1);
    drive(0, 0, 8'hFF, 3'b111, 8'hA5, 3'd5, 4'hC, 1'b1);
    chk_all("R1 R3 R5 no prefix", 16'h00A5, 5'd5, 5'd12, 1'b0, 1'b1);
  endtask

  task automatic t_full;
    drive(0, 1, 8'h12, 3'b111, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h34, 3'd7, 4'hF, 1'b1);
    chk_all("R2 R9 R5 prefixed", 16'h1234, 5'd31, 5'd31, 1'b1, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h34, 3'd7, 4'hF, 1'b1);
    chk_all("R3 cleared after use", 16'h0034, 5'd7, 5'd15, 1'b0, 1'b1);
  endtask

  task automatic t_zero_abs;
    drive(0, 1, 8'h00, 3'b000, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h55, 3'd1, 4'd2, 1'b1);
    chk_all("R5 zero prefix absolute", 16'h0055, 5'd1, 5'd2, 1'b1, 1'b0);
  endtask

  task automatic t_map;
    drive(0, 1, 8'h01, 3'b001, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h10, 3'd2, 4'd3, 1'b0);
    chk_all("R4 idx bit0 to src4", 16'h0110, 5'd2, 5'd19, 1'b0, 1'b0);
    drive(0, 1, 8'h02, 3'b010, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h20, 3'd2, 4'd3, 1'b0);
    chk_all("R4 idx bit1 to dst3", 16'h0220, 5'd10, 5'd3, 1'b0, 1'b0);
    drive(0, 1, 8'h04, 3'b100, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h40, 3'd2, 4'd3, 1'b0);
    chk_all("R4 idx bit2 to dst4", 16'h0440, 5'd18, 5'd3, 1'b0, 1'b0);
  endtask

  task automatic t_b2b;
    drive(0, 1, 8'hAB, 3'b010, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 1, 8'hCD, 3'b001, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'hEF, 3'd1, 4'd1, 1'b1);
    chk_all("R6 second prefix wins", 16'hCDEF, 5'd1, 5'd17, 1'b1, 1'b0);
  endtask

  task automatic t_stall;
    drive(0, 1, 8'h9C, 3'b110, 8'h00, 3'd0, 4'd0, 1'b0);
    drive(1, 1, 8'h33, 3'b001, 8'h11, 3'd4, 4'd6, 1'b1);
    chk_all("R7 stall with write", 16'h9C11, 5'd28, 5'd6, 1'b1, 1'b0);
    drive(1, 0, 8'h00, 3'b000, 8'h22, 3'd4, 4'd6, 1'b1);
    chk_all("R7 stall held", 16'h9C22, 5'd28, 5'd6, 1'b1, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h44, 3'd4, 4'd6, 1'b1);
    chk_all("R7 released consume", 16'h9C44, 5'd28, 5'd6, 1'b1, 1'b0);
    drive(0, 0, 8'h00, 3'b000, 8'h44, 3'd4, 4'd6, 1'b1);
    chk_all("R7 cleared after release", 16'h0044, 5'd4, 5'd6, 1'b0, 1'b1);
  endtask

  task automatic t_midreset;
    drive(0, 1, 8'h77, 3'b111, 8'h00, 3'd0, 4'd0, 1'b0);
    @(negedge clk);
    pfx_wr_i = 1'b0; imm_lo_i = 8'h66; dst_idx_i = 3'd6; src_idx_i = 4'd6; branch_i = 1'b1;
    rst_n = 1'b0;
    #1;
    chk_all("R8 async reset clears", 16'h0066, 5'd6, 5'd6, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; stall_i = 0; pfx_wr_i = 0; pfx_data_i = '0; pfx_idx_i = '0;
    imm_lo_i = '0; dst_idx_i = '0; src_idx_i = '0; branch_i = 0;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_plain();
    t_full();
    t_zero_abs();
    t_map();
    t_b2b();
    t_stall();
    t_midreset();
    t_full();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule